// File: doc/BRIEF.md
# Trap Configuration and Fault Qualifier

This block holds one 32-bit control word and turns execution events into handling decisions. A privileged agent loads the word over a small register port. The word's bits decide several things: whether a zero-divisor divide traps or returns a zero quotient, whether misaligned halfword and word accesses raise a usage fault, and whether a data bus error inside a handler running at priority -1 or -2 is dropped or locks the core. The word also gates entry to thread mode while exceptions are still active, and it decides whether unprivileged code may write the software interrupt trigger register.

Each event arrives as a single-cycle pulse on its own input. All decisions are registered, so every result appears on the output one clock after its event. Misaligned multi-word and doubleword transfers always raise the usage fault, whatever the control word holds. The stack-alignment bit is exported for the exception stacking logic.

Top module: `trap_cfg_qual`

## Requirements
- R1: After a synchronous reset, the control word reads 0x0000_0200, `stk_align8_o` is 1, and every decision output is 0.
- R2: Only bits 9, 8, 4, 3, 1 and 0 are writable. All other bits read 0, and writing them has no effect.
- R3: A write with `cfg_priv` low is ignored, so the control word keeps its value.
- R4: A divide whose divisor is 0 raises `div_trap_o` when bit 4 is 1. When bit 4 is 0, it raises `quot_zero_o` and does not trap. A divide with a nonzero divisor raises neither output.
- R5: When bit 3 is 1, a misaligned access raises `usage_fault_o`. With bit 3 at 0, a plain access never faults. Size encoding is 0 = byte, 1 = halfword, 2 = word. A halfword is misaligned when address bit 0 is 1. A word is misaligned when address bits 1:0 are nonzero. A byte is never misaligned.
- R6: A multi-word or doubleword transfer (`mem_multi` high) whose address bits 1:0 are nonzero raises `usage_fault_o` whatever bit 3 holds. With those address bits at 0, it does not fault.
- R7: A data bus error at priority -1 or -2 raises `berr_ignore_o` when bit 8 is 1 and `lockup_o` when bit 8 is 0. At most one of the three bus-error outputs is high in any cycle.
- R8: A data bus error at any other priority (0 and above, or below -2) raises `bus_fault_o` and never `lockup_o` or `berr_ignore_o`.
- R9: A thread-mode entry request is permitted when bit 0 is 1, or when the active-exception count is 0.
- R10: An unprivileged write attempt to the software interrupt trigger register is permitted only when bit 1 is 1.
- R11: `stk_align8_o` follows bit 9 of the control word (0 = 4-byte, 1 = 8-byte).
- R12: Each decision output is high for exactly the one cycle after its event. Read data is valid the cycle after `cfg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_rd | input | 1 | Control word read strobe |
| cfg_priv | input | 1 | Access is privileged |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| div_valid | input | 1 | Divide executes this cycle |
| div_divisor | input | 32 | Divisor operand |
| mem_valid | input | 1 | Load or store executes this cycle |
| mem_size | input | 2 | 0 byte, 1 halfword, 2 word |
| mem_addr | input | 32 | Access address |
| mem_multi | input | 1 | Multi-word or doubleword transfer |
| bus_err | input | 1 | Data bus error on a load or store |
| exec_prio | input | 9 | Current execution priority, signed |
| thr_req | input | 1 | Request to return to thread mode |
| act_cnt | input | 9 | Number of active exceptions |
| stir_unpriv_wr | input | 1 | Unprivileged write to the trigger register |
| div_trap_o | output | 1 | Divide-by-zero trap |
| quot_zero_o | output | 1 | Force quotient to 0 |
| usage_fault_o | output | 1 | Misalignment usage fault |
| bus_fault_o | output | 1 | Bus fault |
| lockup_o | output | 1 | Lockup |
| berr_ignore_o | output | 1 | Bus error ignored |
| thr_permit_o | output | 1 | Thread entry permitted |
| stir_permit_o | output | 1 | Trigger register write permitted |
| stk_align8_o | output | 1 | 8-byte stack alignment selected |

## Verification
Every decision passes through one register, so it is due one clock after its event. A control-word write reaches the decisions on the event that follows it. Read data also arrives one clock after the strobe. The bench drives inputs on the falling edge and samples on the next falling edge, so each sample falls exactly one rising edge after its stimulus. It then clears the event and checks that the output drops one cycle later.

// File: rtl/trapcfg_pkg.sv
package trapcfg_pkg;

  localparam int unsigned CW_W = 32;

  // Bit positions are decoded by software, so they stay fixed.
  localparam int unsigned B_THR_ANY   = 0;
  localparam int unsigned B_STIR_USR  = 1;
  localparam int unsigned B_UNAL_TRAP = 3;
  localparam int unsigned B_DIV_TRAP  = 4;
  localparam int unsigned B_BERR_IGN  = 8;
  localparam int unsigned B_STK8      = 9;

  localparam logic [CW_W-1:0] WR_MASK =
    (CW_W'(1) << B_THR_ANY)  | (CW_W'(1) << B_STIR_USR) |
    (CW_W'(1) << B_UNAL_TRAP)| (CW_W'(1) << B_DIV_TRAP) |
    (CW_W'(1) << B_BERR_IGN) | (CW_W'(1) << B_STK8);

  localparam logic [CW_W-1:0] RST_VAL = CW_W'(1) << B_STK8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic stk8;
    logic berr_ign;
    logic div_trap;
    logic unal_trap;
    logic stir_usr;
    logic thr_any;
  } cfg_bits_t;

  typedef struct packed {
    logic div_trap;
    logic quot_zero;
    logic usage_fault;
    logic bus_fault;
    logic lockup;
    logic berr_ignore;
    logic thr_permit;
    logic stir_permit;
  } decision_t;

  function automatic cfg_bits_t unpack_cfg(input logic [CW_W-1:0] w);
    cfg_bits_t c;
    c.stk8      = w[B_STK8];
    c.berr_ign  = w[B_BERR_IGN];
    c.div_trap  = w[B_DIV_TRAP];
    c.unal_trap = w[B_UNAL_TRAP];
    c.stir_usr  = w[B_STIR_USR];
    c.thr_any   = w[B_THR_ANY];
    return c;
  endfunction

endpackage

// File: rtl/cfg_word_reg.sv
module cfg_word_reg
  import trapcfg_pkg::*;
#(
  parameter int unsigned DATA_W = CW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic              priv,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] word_q
);

  localparam logic [DATA_W-1:0] MASK = DATA_W'(WR_MASK);
  localparam logic [DATA_W-1:0] INIT = DATA_W'(RST_VAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= INIT;
    end else if (wr && priv) begin
      word_q <= wdata & MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd ? word_q : '0;
    end
  end

endmodule

// File: rtl/misalign_det.sv
module misalign_det
  import trapcfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              valid,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic              multi,
  output logic              plain_mis,
  output logic              multi_mis
);

  logic word_off;
  logic half_off;

  assign word_off = |addr[1:0];
  assign half_off = addr[0];

  always_comb begin
    plain_mis = 1'b0;
    if (valid && !multi) begin
      unique case (acc_size_e'(size))
        SZ_HALF: plain_mis = half_off;
        SZ_WORD: plain_mis = word_off;
        default: plain_mis = 1'b0;
      endcase
    end
  end

  assign multi_mis = valid && multi && word_off;

endmodule

// File: rtl/event_qual.sv
module event_qual
  import trapcfg_pkg::*;
#(
  parameter int unsigned DIV_W   = 32,
  parameter int unsigned PRIO_W  = 9,
  parameter int unsigned ACT_W   = 9,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  cfg_bits_t         cfg,
  input  logic              div_valid,
  input  logic [DIV_W-1:0]  div_divisor,
  input  logic              plain_mis,
  input  logic              multi_mis,
  input  logic              bus_err,
  input  logic [PRIO_W-1:0] exec_prio,
  input  logic              thr_req,
  input  logic [ACT_W-1:0]  act_cnt,
  input  logic              stir_unpriv_wr,
  output decision_t         dec
);

  localparam logic signed [PRIO_W-1:0] PRIO_M1 = -1;
  localparam logic signed [PRIO_W-1:0] PRIO_M2 = -2;

  decision_t d_c;
  logic      div_zero;
  logic      high_prio;

  assign div_zero  = div_valid && (div_divisor == '0);
  assign high_prio = ($signed(exec_prio) == PRIO_M1) ||
                     ($signed(exec_prio) == PRIO_M2);

  always_comb begin
    d_c             = '0;
    d_c.div_trap    = div_zero && cfg.div_trap;
    d_c.quot_zero   = div_zero && !cfg.div_trap;
    d_c.usage_fault = multi_mis || (plain_mis && cfg.unal_trap);
    if (bus_err) begin
      if (high_prio) begin
        d_c.berr_ignore = cfg.berr_ign;
        d_c.lockup      = !cfg.berr_ign;
      end else begin
        d_c.bus_fault   = 1'b1;
      end
    end
    d_c.thr_permit  = thr_req && (cfg.thr_any || (act_cnt == '0));
    d_c.stir_permit = stir_unpriv_wr && cfg.stir_usr;
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) dec <= '0;
        else     dec <= d_c;
      end
    end else begin : g_comb
      assign dec = d_c;
    end
  endgenerate

endmodule

// File: rtl/trap_cfg_qual.sv
module trap_cfg_qual
  import trapcfg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DIV_W  = 32,
  parameter int unsigned PRIO_W = 9,
  parameter int unsigned ACT_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic              cfg_priv,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              div_valid,
  input  logic [DIV_W-1:0]  div_divisor,
  input  logic              mem_valid,
  input  logic [1:0]        mem_size,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_multi,
  input  logic              bus_err,
  input  logic [PRIO_W-1:0] exec_prio,
  input  logic              thr_req,
  input  logic [ACT_W-1:0]  act_cnt,
  input  logic              stir_unpriv_wr,
  output logic              div_trap_o,
  output logic              quot_zero_o,
  output logic              usage_fault_o,
  output logic              bus_fault_o,
  output logic              lockup_o,
  output logic              berr_ignore_o,
  output logic              thr_permit_o,
  output logic              stir_permit_o,
  output logic              stk_align8_o
);

  logic [DATA_W-1:0] word_q;
  cfg_bits_t         cfg;
  logic              plain_mis;
  logic              multi_mis;
  decision_t         dec;

  cfg_word_reg #(.DATA_W(DATA_W)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .wr    (cfg_wr),
    .rd    (cfg_rd),
    .priv  (cfg_priv),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .word_q(word_q)
  );

  assign cfg = unpack_cfg(CW_W'(word_q));

  misalign_det #(.ADDR_W(ADDR_W)) u_mis (
    .valid    (mem_valid),
    .size     (mem_size),
    .addr     (mem_addr),
    .multi    (mem_multi),
    .plain_mis(plain_mis),
    .multi_mis(multi_mis)
  );

  event_qual #(
    .DIV_W  (DIV_W),
    .PRIO_W (PRIO_W),
    .ACT_W  (ACT_W),
    .OUT_REG(1'b1)
  ) u_qual (
    .clk           (clk),
    .rst           (rst),
    .cfg           (cfg),
    .div_valid     (div_valid),
    .div_divisor   (div_divisor),
    .plain_mis     (plain_mis),
    .multi_mis     (multi_mis),
    .bus_err       (bus_err),
    .exec_prio     (exec_prio),
    .thr_req       (thr_req),
    .act_cnt       (act_cnt),
    .stir_unpriv_wr(stir_unpriv_wr),
    .dec           (dec)
  );

  assign div_trap_o    = dec.div_trap;
  assign quot_zero_o   = dec.quot_zero;
  assign usage_fault_o = dec.usage_fault;
  assign bus_fault_o   = dec.bus_fault;
  assign lockup_o      = dec.lockup;
  assign berr_ignore_o = dec.berr_ignore;
  assign thr_permit_o  = dec.thr_permit;
  assign stir_permit_o = dec.stir_permit;
  assign stk_align8_o  = cfg.stk8;

endmodule

// File: rtl/trap_cfg_qual_chk.sv
module trap_cfg_qual_chk
  import trapcfg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DIV_W  = 32,
  parameter int unsigned PRIO_W = 9,
  parameter int unsigned ACT_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic              cfg_priv,
  input logic [DATA_W-1:0] word_q,
  input logic              div_valid,
  input logic [DIV_W-1:0]  div_divisor,
  input logic              mem_valid,
  input logic [1:0]        mem_size,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_multi,
  input logic              bus_err,
  input logic [PRIO_W-1:0] exec_prio,
  input logic              thr_req,
  input logic [ACT_W-1:0]  act_cnt,
  input logic              div_trap_o,
  input logic              quot_zero_o,
  input logic              usage_fault_o,
  input logic              bus_fault_o,
  input logic              lockup_o,
  input logic              berr_ignore_o,
  input logic              thr_permit_o
);

  localparam logic [DATA_W-1:0] MASK = DATA_W'(WR_MASK);
  localparam logic [DATA_W-1:0] INIT = DATA_W'(RST_VAL);

  p_reset_val_r1: assert property (@(posedge clk)
    rst |=> (word_q == INIT));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (word_q & ~MASK) == '0);

  p_unpriv_wr_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_priv) |=> $stable(word_q));

  p_div_trap_r4: assert property (@(posedge clk) disable iff (rst)
    (div_valid && div_divisor == '0 && word_q[B_DIV_TRAP]) |=> (div_trap_o && !quot_zero_o));

  p_div_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    (div_valid && div_divisor != '0) |=> (!div_trap_o && !quot_zero_o));

  p_byte_never_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_multi && mem_size == 2'd0) |=> !usage_fault_o);

  p_multi_fault_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_multi && mem_addr[1:0] != 2'b00) |=> usage_fault_o);

  p_berr_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_fault_o, lockup_o, berr_ignore_o}));

  p_berr_low_prio_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_err && !exec_prio[PRIO_W-1]) |=> (bus_fault_o && !lockup_o && !berr_ignore_o));

  p_thr_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (thr_req && act_cnt == '0) |=> thr_permit_o);

endmodule

bind trap_cfg_qual trap_cfg_qual_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W), .PRIO_W(PRIO_W), .ACT_W(ACT_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_priv(cfg_priv), .word_q(word_q),
  .div_valid(div_valid), .div_divisor(div_divisor), .mem_valid(mem_valid),
  .mem_size(mem_size), .mem_addr(mem_addr), .mem_multi(mem_multi),
  .bus_err(bus_err), .exec_prio(exec_prio), .thr_req(thr_req), .act_cnt(act_cnt),
  .div_trap_o(div_trap_o), .quot_zero_o(quot_zero_o), .usage_fault_o(usage_fault_o),
  .bus_fault_o(bus_fault_o), .lockup_o(lockup_o), .berr_ignore_o(berr_ignore_o),
  .thr_permit_o(thr_permit_o)
);

// File: tb/tb_trap_cfg_qual.sv
module tb_trap_cfg_qual;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 9;
  localparam int AW = 9;

  typedef struct packed {
    logic [3:0]        req;
    logic [9:0]        cfg;
    logic              dv;
    logic              dz;
    logic              mv;
    logic [1:0]        sz;
    logic [1:0]        ad;
    logic              mu;
    logic              be;
    logic signed [3:0] pr;
    logic              tr;
    logic [3:0]        ac;
    logic              st;
    logic [7:0]        exp;   // div_trap,quot_zero,uf,bf,lock,ign,thr,stir
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [0:NV-1] = '{
    '{4'd4,  10'h010, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'sd0,  1'b0, 4'd0, 1'b0, 8'b1000_0000}, // R4 trap
    '{4'd4,  10'h000, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'sd0,  1'b0, 4'd0, 1'b0, 8'b0100_0000}, // R4 zero quotient
    '{4'd4,  10'h010, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'sd0,  1'b0, 4'd0, 1'b0, 8'b0000_0000}, // R4 nonzero
    '{4'd5,  10'h008, 1'b0, 1'b0, 1'b1, 2'd1, 2'd1, 1'b0, 1'b0, 4'sd0,  1'b0, 4'd0, 1'b0, 8'b0010_0000}, // R5 half odd
    '{4'd5,  10'h008, 1'b0, 1'b0, 1'b1, 2'd1, 2'd2, 1'b0, 1'b0, 4'sd0,  1'b0, 4'd0, 1'b0, 8'b0000_0000}, // R5 half even
    '{4'd5,  10'h008, 1'b0, 1'b0, 1'b1, 2'd2, 2'd2, 1'b0, 1'b0, 4'sd0,  1'b0, 4'd0, 1'b0, 8'b0010_0000}, // R5 word off 2
    '{4'd5,  10'h008, 1'b0, 1'b0, 1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 4'sd0,  1'b0, 4'd0, 1'b0, 8'b0000_0000}, // R5 byte
    '{4'd5,  10'h000, 1'b0, 1'b0, 1'b1, 2'd2, 2'd1, 1'b0, 1'b0, 4'sd0,  1'b0, 4'd0, 1'b0, 8'b0000_0000}, // R5 trap off
    '{4'd6,  10'h000, 1'b0, 1'b0, 1'b1, 2'd2, 2'd2, 1'b1, 1'b0, 4'sd0,  1'b0, 4'd0, 1'b0, 8'b0010_0000}, // R6 multi off
    '{4'd6,  10'h008, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 1'b1, 1'b0, 4'sd0,  1'b0, 4'd0, 1'b0, 8'b0000_0000}, // R6 multi aligned
    '{4'd7,  10'h100, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, -4'sd1, 1'b0, 4'd0, 1'b0, 8'b0000_0100}, // R7 ignore
    '{4'd7,  10'h000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, -4'sd2, 1'b0, 4'd0, 1'b0, 8'b0000_1000}, // R7 lockup
    '{4'd7,  10'h000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, -4'sd1, 1'b0, 4'd0, 1'b0, 8'b0000_1000}, // R7 lockup -1
    '{4'd8,  10'h100, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 4'sd0,  1'b0, 4'd0, 1'b0, 8'b0001_0000}, // R8 prio 0
    '{4'd8,  10'h000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 4'sd5,  1'b0, 4'd0, 1'b0, 8'b0001_0000}, // R8 prio 5
    '{4'd8,  10'h100, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, -4'sd3, 1'b0, 4'd0, 1'b0, 8'b0001_0000}, // R8 prio -3
    '{4'd9,  10'h000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'sd0,  1'b1, 4'd0, 1'b0, 8'b0000_0010}, // R9 idle
    '{4'd9,  10'h000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'sd0,  1'b1, 4'd3, 1'b0, 8'b0000_0000}, // R9 nested, blocked
    '{4'd9,  10'h001, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'sd0,  1'b1, 4'd3, 1'b0, 8'b0000_0010}, // R9 any level
    '{4'd10, 10'h002, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'sd0,  1'b0, 4'd0, 1'b1, 8'b0000_0001}  // R10 permitted
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_priv = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        div_valid = 1'b0;
  logic [31:0] div_divisor = '0;
  logic        mem_valid = 1'b0;
  logic [1:0]  mem_size = '0;
  logic [31:0] mem_addr = '0;
  logic        mem_multi = 1'b0, bus_err = 1'b0;
  logic [PW-1:0] exec_prio = '0;
  logic        thr_req = 1'b0;
  logic [AW-1:0] act_cnt = '0;
  logic        stir_unpriv_wr = 1'b0;
  logic        div_trap_o, quot_zero_o, usage_fault_o, bus_fault_o, lockup_o;
  logic        berr_ignore_o, thr_permit_o, stir_permit_o, stk_align8_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_cfg_qual dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_priv(cfg_priv),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .div_valid(div_valid),
    .div_divisor(div_divisor), .mem_valid(mem_valid), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_multi(mem_multi), .bus_err(bus_err),
    .exec_prio(exec_prio), .thr_req(thr_req), .act_cnt(act_cnt),
    .stir_unpriv_wr(stir_unpriv_wr), .div_trap_o(div_trap_o),
    .quot_zero_o(quot_zero_o), .usage_fault_o(usage_fault_o),
    .bus_fault_o(bus_fault_o), .lockup_o(lockup_o), .berr_ignore_o(berr_ignore_o),
    .thr_permit_o(thr_permit_o), .stir_permit_o(stir_permit_o),
    .stk_align8_o(stk_align8_o)
  );

  function automatic logic [7:0] outs();
    return {div_trap_o, quot_zero_o, usage_fault_o, bus_fault_o,
            lockup_o, berr_ignore_o, thr_permit_o, stir_permit_o};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] d, input logic priv);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_priv = priv; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_priv = 1'b0;
  endtask

  task automatic read_cfg(output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1;
    @(negedge clk);
    d = cfg_rdata;
    cfg_rd = 1'b0;
  endtask

  task automatic clear_events();
    div_valid = 1'b0; div_divisor = '0; mem_valid = 1'b0; mem_size = '0;
    mem_addr = '0; mem_multi = 1'b0; bus_err = 1'b0; exec_prio = '0;
    thr_req = 1'b0; act_cnt = '0; stir_unpriv_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 outputs", {24'h0, outs()}, 32'h0);
    check("R1 stk_align8", {31'h0, stk_align8_o}, 32'h1);
    read_cfg(rd);
    check("R1 readback", rd, 32'h0000_0200);

    // R2 reserved bits
    write_cfg(32'hFFFF_FFFF, 1'b1);
    read_cfg(rd);
    check("R2 reserved masked", rd, 32'h0000_031B);

    // R3 unprivileged write ignored
    write_cfg(32'h0000_0000, 1'b0);
    read_cfg(rd);
    check("R3 unpriv write", rd, 32'h0000_031B);

    // R11 stack alignment follows bit 9
    write_cfg(32'h0000_0000, 1'b1);
    check("R11 stk 4-byte", {31'h0, stk_align8_o}, 32'h0);
    write_cfg(32'h0000_0200, 1'b1);
    check("R11 stk 8-byte", {31'h0, stk_align8_o}, 32'h1);

    // Table walk (R4..R10)
    for (int i = 0; i < NV; i++) begin
      write_cfg({22'h0, VEC[i].cfg}, 1'b1);
      div_valid      = VEC[i].dv;
      div_divisor    = VEC[i].dz ? 32'h0 : 32'h7;
      mem_valid      = VEC[i].mv;
      mem_size       = VEC[i].sz;
      mem_addr       = {28'h100_0000, 2'b00, VEC[i].ad};
      mem_multi      = VEC[i].mu;
      bus_err        = VEC[i].be;
      exec_prio      = {{(PW-4){VEC[i].pr[3]}}, VEC[i].pr};
      thr_req        = VEC[i].tr;
      act_cnt        = AW'(VEC[i].ac);
      stir_unpriv_wr = VEC[i].st;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), {24'h0, outs()}, {24'h0, VEC[i].exp});
      clear_events();
    end

    // R10 blocked when bit 1 clear
    write_cfg(32'h0, 1'b1);
    stir_unpriv_wr = 1'b1;
    @(negedge clk);
    check("R10 blocked", {31'h0, stir_permit_o}, 32'h0);
    clear_events();

    // R12 one-cycle pulse: output drops the cycle after the event ends
    write_cfg(32'h0000_0010, 1'b1);
    div_valid = 1'b1; div_divisor = '0;
    @(negedge clk);
    check("R12 pulse high", {31'h0, div_trap_o}, 32'h1);
    clear_events();
    @(negedge clk);
    check("R12 pulse low", {24'h0, outs()}, 32'h0);

    // R1 re-reset restores default
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    read_cfg(rd);
    check("R1 re-reset", rd, 32'h0000_0200);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule